// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Masked Output Writes and Shared Interrupt

This block controls sixteen general-purpose pins from a 32-bit register bus. Software picks each pin's direction and drives output levels. Output writes carry a per-pin write mask, so one store changes any subset of pins and needs no read-modify-write. Pin levels pass through a two-flop synchronizer. They are read back as a pin-state word and also feed the interrupt outputs.

The lower eight pins each drive their own level-sensitive interrupt line, with no enable. Each of the upper eight pins is ANDed with its own enable bit. The eight results are ORed into one active-high shared request.

A two-bit control register gives explicit clock and reset control:
- The reset bit clears the bank and holds it cleared.
- The clock bit freezes input sampling when it is 0, to save power.
- Bring-up is a write of 3 followed by a write of 1.

Top module: `pinbank_ctrl`

## Requirements
- R1: After `rst_n` is released, the control register reads 2 (bit 1 reset, bit 0 clock enable). Direction, output and interrupt-enable registers read 0. `pad_oe`, `pad_out`, `irq_direct` and `irq_shared` are all 0.
- R2: A write to offset 0x00 loads bits 15:0 into the direction register. A 1 bit makes that pin an output, driven on `pad_oe` from the next cycle.
- R3: A write to offset 0x08 updates only the pins whose mask bit is 1. The mask is in `reg_wdata[31:16]` and the new levels are in `reg_wdata[15:0]`. All other pins keep their level on `pad_out`. A write with an all-zero mask changes nothing.
- R4: A read of offset 0x0C returns the synchronized pin levels in bits 15:0. With the clock enabled, a change on `pad_in` reaches this value after two rising edges.
- R5: `irq_direct[i]` for pins 0 to 7 equals the synchronized level of pin i, whatever the interrupt-enable bits hold.
- R6: `irq_shared` is the OR over pins 8 to 15 of the synchronized level ANDed with interrupt-enable bit i. The enable bits sit at offset 0x10, bits 15:8. Enable bits 7:0 do not affect it.
- R7: While control bit 1 is set, the direction, output, interrupt-enable and synchronizer state are held at 0. Writes to any offset other than 0x14 are ignored.
- R8: While control bit 0 is 0, the synchronizer does not sample. Pin state, `irq_direct` and `irq_shared` keep their values whatever `pad_in` does.
- R9: A read (`reg_valid` high, `reg_write` low) returns its data on `rd_data` with `rd_valid` high exactly one cycle later. Offsets with no register, such as 0x04, read 0.
- R10: A write to offset 0x14 loads bits 1:0 into the control register, and it can be read back. Writing 3 then 1 leaves the bank running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access request this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read) |
| rd_data | output | 32 | Read data |
| pad_in | input | 16 | Raw pin levels from the pads |
| pad_out | output | 16 | Output levels to the pads |
| pad_oe | output | 16 | Output enables to the pads (1 = drive) |
| irq_direct | output | 8 | Per-pin interrupt levels for pins 0 to 7 |
| irq_shared | output | 1 | Combined gated request for pins 8 to 15 |

## Verification
Masked output writes are tried with three masks:
- A full mask shows that the data field is applied at all.
- A partial mask shows that unmasked pins keep their level.
- An empty mask shows that the data field alone has no effect.

The shared request is driven with a high upper pin under three enable settings: no enable, its own enable, and the enable of a neighbouring pin. This tells the per-pin AND apart from a plain OR of the levels. The lower enable bits are also set to show that they have no effect on the shared request.

Input patterns are changed while the clock bit is 0 and while the reset bit is set. This tells frozen and cleared state apart from live sampling.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_DIR = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_OUT = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_PIN = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_IEN = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_CTL = 5'h14;
  localparam int CTL_CLK = 0;
  localparam int CTL_RST = 1;
  localparam logic [1:0] CTL_RESET_VAL = 2'b10;
endpackage

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int N_PINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [N_PINS-1:0] dir_q,
  output logic [N_PINS-1:0] out_q,
  output logic [N_PINS-1:0] ien_q,
  output logic [1:0]        ctl_q
);
  localparam int MASK_LSB = DATA_W / 2;

  logic [N_PINS-1:0] wmask;
  assign wmask = wr_data[MASK_LSB +: N_PINS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RESET_VAL;
      dir_q <= '0;
      out_q <= '0;
      ien_q <= '0;
    end else begin
      if (wr_en && wr_addr == OFS_CTL) ctl_q <= wr_data[1:0];
      if (ctl_q[CTL_RST]) begin
        dir_q <= '0;
        out_q <= '0;
        ien_q <= '0;
      end else if (wr_en) begin
        case (wr_addr)
          OFS_DIR: dir_q <= wr_data[N_PINS-1:0];
          OFS_OUT: out_q <= (out_q & ~wmask) | (wr_data[N_PINS-1:0] & wmask);
          OFS_IEN: ien_q <= wr_data[N_PINS-1:0];
          default: ;
        endcase
      end
    end
  end

  // R7
  held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[CTL_RST] |=> (dir_q == '0 && out_q == '0 && ien_q == '0));

  // R3
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_OUT && !ctl_q[CTL_RST]) |=>
      (((out_q ^ $past(out_q)) & ~$past(wmask)) == '0));
endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] nxt;
    if (g == 0) begin : g_first
      assign nxt = d;
    end else begin : g_rest
      assign nxt = st[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st[g] <= '0;
      else if (clr) st[g] <= '0;
      else if (en)  st[g] <= nxt;
    end
  end

  assign q = st[STAGES-1];

  // R8
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(q));
endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq #(
  parameter int N_PINS   = 16,
  parameter int N_DIRECT = 8
) (
  input  logic [N_PINS-1:0]   lvl,
  input  logic [N_PINS-1:0]   ien,
  output logic [N_DIRECT-1:0] irq_direct,
  output logic                irq_shared
);
  localparam int N_SHARED = N_PINS - N_DIRECT;

  logic [N_SHARED-1:0] gated;

  for (genvar i = 0; i < N_SHARED; i++) begin : g_gate
    assign gated[i] = lvl[N_DIRECT+i] & ien[N_DIRECT+i];
  end

  assign irq_direct = lvl[N_DIRECT-1:0];
  assign irq_shared = |gated;
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int N_PINS   = 16,
  parameter int N_DIRECT = 8,
  parameter int N_SYNC   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_valid,
  input  logic                reg_write,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [N_PINS-1:0]   pad_in,
  output logic [N_PINS-1:0]   pad_out,
  output logic [N_PINS-1:0]   pad_oe,
  output logic [N_DIRECT-1:0] irq_direct,
  output logic                irq_shared
);
  localparam int PAD_W = DATA_W - N_PINS;

  logic [N_PINS-1:0] dir_q, out_q, ien_q, lvl;
  logic [1:0]        ctl_q;
  logic              wr_en, rd_req;
  logic [DATA_W-1:0] rd_mux;

  assign wr_en  = reg_valid & reg_write;
  assign rd_req = reg_valid & ~reg_write;

  pinbank_regs #(.N_PINS(N_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .dir_q(dir_q), .out_q(out_q), .ien_q(ien_q),
    .ctl_q(ctl_q)
  );

  pinbank_sync #(.W(N_PINS), .STAGES(N_SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .clr(ctl_q[CTL_RST]), .en(ctl_q[CTL_CLK]),
    .d(pad_in), .q(lvl)
  );

  pinbank_irq #(.N_PINS(N_PINS), .N_DIRECT(N_DIRECT)) u_irq (
    .lvl(lvl), .ien(ien_q), .irq_direct(irq_direct), .irq_shared(irq_shared)
  );

  always_comb begin
    case (reg_addr)
      OFS_DIR: rd_mux = {{PAD_W{1'b0}}, dir_q};
      OFS_OUT: rd_mux = {{PAD_W{1'b0}}, out_q};
      OFS_PIN: rd_mux = {{PAD_W{1'b0}}, lvl};
      OFS_IEN: rd_mux = {{PAD_W{1'b0}}, ien_q};
      OFS_CTL: rd_mux = {{(DATA_W-2){1'b0}}, ctl_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_mux;
    end
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;

  // R6
  shared_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q[N_PINS-1:N_DIRECT] == '0) |-> !irq_shared);

  // R9
  rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  // R7
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[CTL_RST] |=> (pad_oe == '0 && !irq_shared));
endmodule

// File: tb/pinbank_ctrl_tb.sv
`timescale 1ns/1ps
module pinbank_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [15:0] pad_in = '0, pad_out, pad_oe;
  logic [7:0]  irq_direct;
  logic        irq_shared;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pinbank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_direct(irq_direct), .irq_shared(irq_shared)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] d; logic v;
    rd(5'h14, d, v); check("R1 ctl", d, 32'h2);
    rd(5'h00, d, v); check("R1 dir", d, 32'h0);
    rd(5'h10, d, v); check("R1 ien", d, 32'h0);
    check("R1 pad_oe", {16'h0, pad_oe}, 32'h0);
    check("R1 pad_out", {16'h0, pad_out}, 32'h0);
    check("R1 irq", {23'h0, irq_shared, irq_direct}, 32'h0);
  endtask

  task automatic t_held_in_reset();
    logic [31:0] d; logic v;
    pad_in = 16'hFFFF;
    wr(5'h00, 32'h0000_FFFF);
    wr(5'h08, 32'hFFFF_FFFF);
    wr(5'h10, 32'h0000_FFFF);
    wait_cyc(3);
    check("R7 pad_oe", {16'h0, pad_oe}, 32'h0);
    check("R7 pad_out", {16'h0, pad_out}, 32'h0);
    rd(5'h10, d, v); check("R7 ien", d, 32'h0);
    rd(5'h0C, d, v); check("R7 pin cleared", d, 32'h0);
    pad_in = 16'h0;
  endtask

  task automatic t_bring_up();
    logic [31:0] d; logic v;
    wr(5'h14, 32'h3);
    rd(5'h14, d, v); check("R10 ctl=3", d, 32'h3);
    wr(5'h14, 32'h1);
    rd(5'h14, d, v); check("R10 ctl=1", d, 32'h1);
  endtask

  task automatic t_direction();
    logic [31:0] d; logic v;
    wr(5'h00, 32'h0000_00F0);
    check("R2 pad_oe", {16'h0, pad_oe}, 32'h00F0);
    rd(5'h00, d, v); check("R2 dir read", d, 32'h00F0);
  endtask

  task automatic t_masked_out();
    logic [31:0] d; logic v;
    wr(5'h08, 32'hFFFF_A5A5);
    check("R3 full mask", {16'h0, pad_out}, 32'hA5A5);
    wr(5'h08, 32'h00F0_0000);
    check("R3 partial mask", {16'h0, pad_out}, 32'hA505);
    wr(5'h08, 32'h0000_FFFF);
    check("R3 empty mask", {16'h0, pad_out}, 32'hA505);
    rd(5'h08, d, v); check("R3 readback", d, 32'hA505);
  endtask

  task automatic t_pin_state();
    logic [31:0] d; logic v;
    wr(5'h10, 32'h0);
    @(negedge clk); pad_in = 16'h1234;
    @(negedge clk);
    check("R4 one edge not yet", {24'h0, irq_direct}, 32'h0);
    @(negedge clk);
    check("R5 direct", {24'h0, irq_direct}, 32'h34);
    rd(5'h0C, d, v); check("R4 pin state", d, 32'h1234);
  endtask

  task automatic t_shared();
    pad_in = 16'h8001;
    wait_cyc(3);
    wr(5'h10, 32'h0000_00FF);
    check("R6 low enables no effect", {31'h0, irq_shared}, 32'h0);
    check("R5 direct unaffected", {24'h0, irq_direct}, 32'h01);
    wr(5'h10, 32'h0000_8000);
    check("R6 own enable", {31'h0, irq_shared}, 32'h1);
    wr(5'h10, 32'h0000_4000);
    check("R6 neighbour enable", {31'h0, irq_shared}, 32'h0);
    wr(5'h10, 32'h0000_8000);
  endtask

  task automatic t_frozen();
    logic [31:0] d; logic v;
    wr(5'h14, 32'h0);
    pad_in = 16'h7F00;
    wait_cyc(4);
    rd(5'h0C, d, v); check("R8 pin frozen", d, 32'h8001);
    check("R8 irq frozen", {23'h0, irq_shared, irq_direct}, 32'h101);
    wr(5'h14, 32'h1);
    wait_cyc(3);
    rd(5'h0C, d, v); check("R8 resumes", d, 32'h7F00);
    check("R6 shared low", {31'h0, irq_shared}, 32'h0);
  endtask

  task automatic t_read_timing();
    logic [31:0] d; logic v;
    rd(5'h04, d, v);
    check("R9 empty offset", d, 32'h0);
    check("R9 rd_valid", {31'h0, v}, 32'h1);
    @(negedge clk);
    check("R9 rd_valid drops", {31'h0, rd_valid}, 32'h0);
  endtask

  task automatic t_reenter_reset();
    logic [31:0] d; logic v;
    wr(5'h14, 32'h2);
    @(negedge clk);
    check("R7 out cleared", {16'h0, pad_out}, 32'h0);
    check("R7 oe cleared", {16'h0, pad_oe}, 32'h0);
    rd(5'h0C, d, v); check("R7 pins cleared", d, 32'h0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset_state();
    t_held_in_reset();
    t_bring_up();
    t_direction();
    t_masked_out();
    t_pin_state();
    t_shared();
    t_frozen();
    t_read_timing();
    t_reenter_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule